// File: doc/BRIEF.md
# Programmable Periodic Interrupt Generator

This block turns a slow 32.768 kHz timebase into periodic interrupt events. A one-cycle enable pulse marks each timebase tick and advances a free-running 16-bit counter that starts at zero after reset. A 4-bit rate code selects a period that is a power of two in ticks, and a separate enable bit gates the events. A code of zero produces no events at all.

Events are aligned to the counter itself, not to the moment the configuration changed. An event fires on the tick that moves the counter onto an exact multiple of the selected period. A new code or a newly set enable bit therefore takes effect at the next such multiple after the current count. Each event is a single-cycle pulse together with a flag-set mask of bits 7 and 6 (0xC0). A separate status register outside this block ORs that mask into its flags and raises the interrupt request.

Top module: `prd_irq_gen`

## Requirements
- R1: After reset the counter is zero and `evt_o` is low with `flags_o` equal to 0x00 until a qualifying tick arrives.
- R2: A rate code of 0 never produces an event, whatever the enable bit and tick do.
- R3: When `pie_en` is low no event is produced, though the counter keeps advancing on ticks.
- R4: A nonzero code n selects a period of 2^(n-1) ticks; code 1 gives an event on every tick.
- R5: An event fires on the tick whose new count is an exact multiple of the period. Changing the code mid-run makes the next event land on the next multiple of the new period after the current count.
- R6: Each event is a one-cycle high on `evt_o`, presented in the cycle after the clock edge that sampled the tick, with `flags_o` = 0xC0 (bits 7 and 6) in that cycle and 0x00 in all other cycles.
- R7: In a cycle without `tick` the counter holds and no event is produced.
- R8: The counter wraps from 0xFFFF to 0x0000, and the wrap to zero counts as a boundary for every period.
- R9: Setting `pie_en` part way through a period does not restart the period: the first event comes at the next multiple of the period after the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per 32.768 kHz timebase period |
| rate_code | input | 4 | Period select; 0 disables, n gives 2^(n-1) ticks |
| pie_en | input | 1 | Periodic event enable |
| evt_o | output | 1 | One-cycle periodic event |
| flags_o | output | 8 | Status flag set mask, 0xC0 during an event |

## Verification
The assertions check on every cycle that an event only follows a sampled tick with the enable set and a nonzero code. They also check that the flag mask carries exactly two bits during an event and none otherwise, that code 1 with a tick always fires, and that the block is quiet right after reset. Only the bench scenarios can show the absolute alignment of events to multiples of the period: the first event after a code change or an enable rising mid-period, the behaviour of sparse ticks, and the wrap of the counter to zero. These require a model of the count from reset, which the scoreboard keeps.

// File: rtl/prd_pkg.sv
package prd_pkg;
    localparam int unsigned CNT_W_DEF  = 16;
    localparam int unsigned CODE_W_DEF = 4;
    localparam int unsigned STAT_W_DEF = 8;

    // Mask of the low (code-1) bits; all zero for code 0 or 1.
    function automatic logic [31:0] period_mask(input logic [7:0] code);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < 32; i++) begin
            if (code != 8'd0 && i < int'(code) - 1) begin
                m[i] = 1'b1;
            end
        end
        return m;
    endfunction
endpackage

// File: rtl/prd_rate_decode.sv
module prd_rate_decode #(
    parameter int unsigned CNT_W  = prd_pkg::CNT_W_DEF,
    parameter int unsigned CODE_W = prd_pkg::CODE_W_DEF
) (
    input  logic [CODE_W-1:0] rate_code,
    input  logic              pie_en,
    output logic              active,
    output logic [CNT_W-1:0]  mask
);
    logic [31:0] full_mask;

    always_comb begin
        full_mask = prd_pkg::period_mask(8'(rate_code));
        mask      = full_mask[CNT_W-1:0];
        active    = pie_en && (rate_code != '0);
    end
endmodule

// File: rtl/prd_tick_counter.sv
module prd_tick_counter #(
    parameter int unsigned CNT_W = prd_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_nxt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        cnt_nxt = st_d.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/prd_boundary_det.sv
module prd_boundary_det #(
    parameter int unsigned        CNT_W     = prd_pkg::CNT_W_DEF,
    parameter int unsigned        STAT_W    = prd_pkg::STAT_W_DEF,
    parameter logic [STAT_W-1:0]  FLAG_MASK = 8'hC0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              active,
    input  logic [CNT_W-1:0]  cnt_nxt,
    input  logic [CNT_W-1:0]  mask,
    output logic              evt,
    output logic [STAT_W-1:0] flags
);
    typedef struct packed {
        logic              evt;
        logic [STAT_W-1:0] flags;
    } det_t;

    det_t st_d, st_q;

    always_comb begin
        st_d.evt   = tick && active && ((cnt_nxt & mask) == '0);
        st_d.flags = st_d.evt ? FLAG_MASK : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt   = st_q.evt;
    assign flags = st_q.flags;
endmodule

// File: rtl/prd_irq_gen.sv
module prd_irq_gen #(
    parameter int unsigned       CNT_W     = prd_pkg::CNT_W_DEF,
    parameter int unsigned       CODE_W    = prd_pkg::CODE_W_DEF,
    parameter int unsigned       STAT_W    = prd_pkg::STAT_W_DEF,
    parameter logic [STAT_W-1:0] FLAG_MASK = 8'hC0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CODE_W-1:0] rate_code,
    input  logic              pie_en,
    output logic              evt_o,
    output logic [STAT_W-1:0] flags_o
);
    logic             active;
    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] cnt_nxt;

    prd_rate_decode #(.CNT_W(CNT_W), .CODE_W(CODE_W)) dec_i (
        .rate_code (rate_code),
        .pie_en    (pie_en),
        .active    (active),
        .mask      (mask)
    );

    prd_tick_counter #(.CNT_W(CNT_W)) ctr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cnt_nxt (cnt_nxt)
    );

    prd_boundary_det #(.CNT_W(CNT_W), .STAT_W(STAT_W), .FLAG_MASK(FLAG_MASK)) det_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .active  (active),
        .cnt_nxt (cnt_nxt),
        .mask    (mask),
        .evt     (evt_o),
        .flags   (flags_o)
    );
endmodule

// File: rtl/prd_irq_gen_chk.sv
module prd_irq_gen_chk #(
    parameter int unsigned CODE_W = prd_pkg::CODE_W_DEF,
    parameter int unsigned STAT_W = prd_pkg::STAT_W_DEF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [CODE_W-1:0] rate_code,
    input logic              pie_en,
    input logic              evt_o,
    input logic [STAT_W-1:0] flags_o
);
    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !evt_o); // R1
    AST_CODE_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> ($past(rate_code) != '0)); // R2
    AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> $past(pie_en)); // R3
    AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pie_en && rate_code == CODE_W'(1)) |=> evt_o); // R4
    AST_FLAG_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flags_o) == (evt_o ? 2 : 0)); // R6
    AST_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> $past(tick)); // R7
endmodule

bind prd_irq_gen prd_irq_gen_chk #(.CODE_W(CODE_W), .STAT_W(STAT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .rate_code (rate_code),
    .pie_en    (pie_en),
    .evt_o     (evt_o),
    .flags_o   (flags_o)
);

// File: tb/prd_irq_gen_tb_top.sv
module prd_irq_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] rate_code = 4'd0;
    logic       pie_en = 1'b0;
    logic       evt_o;
    logic [7:0] flags_o;

    int checks = 0;
    int fails  = 0;
    logic [15:0] mdl_cnt = 16'd0;

    typedef struct {
        logic  evt;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    prd_irq_gen dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rate_code(rate_code),
        .pie_en(pie_en), .evt_o(evt_o), .flags_o(flags_o)
    );

    task automatic check(input logic ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // Driver: apply one cycle of stimulus and push its expected result.
    task automatic drive(input logic t, input logic [3:0] code, input logic en,
                         input string tag);
        exp_t e;
        logic [15:0] nxt;
        @(negedge clk);
        tick = t; rate_code = code; pie_en = en;
        nxt = mdl_cnt + (t ? 16'd1 : 16'd0);
        e.evt = 1'b0;
        if (t && en && code != 4'd0) begin
            e.evt = ((32'(nxt) % (32'd1 << (code - 4'd1))) == 0);
        end
        e.tag = tag;
        mdl_cnt = nxt;
        sb_q.push_back(e);
    endtask

    // Monitor: compare after each edge, away from it.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(evt_o === e.evt, e.tag, "evt_o", int'(evt_o), int'(e.evt));
                check(flags_o === (e.evt ? 8'hC0 : 8'h00), e.tag, "flags_o (R6)",
                      int'(flags_o), e.evt ? 32'hC0 : 32'h0);
            end
        end
    end

    initial begin
        #(4 * 190000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(evt_o === 1'b0 && flags_o === 8'h00, "R1", "reset outputs",
              int'({evt_o, flags_o}), 0);
        rst_n = 1'b1;
        // R1 / R7: no ticks, nothing happens, counter stays at zero
        for (int i = 0; i < 5; i++) drive(1'b0, 4'd1, 1'b1, "R7");
        // R2: code zero with ticks
        for (int i = 0; i < 20; i++) drive(1'b1, 4'd0, 1'b1, "R2");
        // R3: enable low with ticks, counter still advances
        for (int i = 0; i < 20; i++) drive(1'b1, 4'd3, 1'b0, "R3");
        // R4: code 1 fires every tick
        for (int i = 0; i < 10; i++) drive(1'b1, 4'd1, 1'b1, "R4");
        // R4 / R6: code 3 with sparse ticks
        for (int i = 0; i < 40; i++) drive(i % 3 == 0, 4'd3, 1'b1, "R6");
        // R5: change code mid-run
        for (int i = 0; i < 13; i++) drive(1'b1, 4'd4, 1'b1, "R5");
        for (int i = 0; i < 40; i++) drive(1'b1, 4'd5, 1'b1, "R5");
        for (int i = 0; i < 9; i++)  drive(1'b1, 4'd2, 1'b1, "R5");
        // R9: enable off part way, then on mid-period
        for (int i = 0; i < 21; i++) drive(1'b1, 4'd5, 1'b0, "R9");
        for (int i = 0; i < 40; i++) drive(1'b1, 4'd5, 1'b1, "R9");
        // R7: idle without ticks at full rate config
        for (int i = 0; i < 10; i++) drive(1'b0, 4'd1, 1'b1, "R7");
        // R8: longest period, run through the 16-bit wrap
        while (mdl_cnt != 16'hFFF0) drive(1'b1, 4'd15, 1'b1, "R5");
        for (int i = 0; i < 40; i++) drive(1'b1, 4'd15, 1'b1, "R8");
        for (int i = 0; i < 8; i++) drive(1'b1, 4'd3, 1'b1, "R8");
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule